// File: doc/BRIEF.md
# Level Interrupt Cause/Mask Aggregator

This block collects seven level-style interrupt sources into one parent interrupt line. Each source sets its own bit in a latched cause register. A separate enable register selects which latched causes may reach the parent line. Software reaches both registers through a 32-bit word interface. The write port is a single-cycle strobe and the read data is combinational on the address.

The cause register has no clear-on-write-one behaviour. Every writable bit simply takes the value written, so software clears a cause by writing 0 to it and can raise one by writing 1. A hardware event in the same cycle as a write always wins, so no event is lost. A third, read-only word reports whether any enabled cause is pending and, if so, the highest-numbered one. Software can therefore service pending sources from the top down.

The parent line comes from a two-state machine, `LINE_QUIET` and `LINE_RAISED`. Transition `RAISE` moves from quiet to raised when the enabled pending set is non-empty. Transition `DROP` moves back to quiet when that set is empty. Both states otherwise hold.

Top module: `irqagg_top`

## Requirements
- R1: After reset, the cause word, the enable word and the highest-pending word all read 0, and `irq_o` is low.
- R2: A high level on `src_i[n]` at a rising clock edge sets cause bit n from that edge on, whether or not the source is enabled.
- R3: A write to offset 0x50 loads cause bits 6..0 with `wdata[6:0]`, so a 1 sets a cause and a 0 clears it; a write of 0 to both 0x50 and 0x54 leaves nothing pending.
- R4: When `src_i[n]` is high in the same cycle as a cause write, cause bit n ends up 1, whatever value was written to it.
- R5: Offset 0x54 is the enable word, where a 1 in bit n enables source n; in both the cause and enable words, bits 31..7 read as 0 and writes to them have no effect.
- R6: `irq_o` is high in the cycle after (cause AND enable) becomes nonzero, and low in the cycle after it becomes zero.
- R7: Offset 0x5C reads bit 31 as 1 when (cause AND enable) is nonzero, with bits 2..0 giving the highest set bit index of that AND; all other bits read 0, and the whole word is 0 when nothing is pending.
- R8: Writes to 0x5C or to any unmapped offset change no register, and reads of unmapped offsets return 0.
- R9: A latched cause whose enable bit is 0 neither raises `irq_o` nor appears in the 0x5C word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | 7 | Level interrupt sources, one per bit |
| wr_en | input | 1 | Write strobe, one word per cycle |
| addr | input | 8 | Byte offset of the word read or written |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| irq_o | output | 1 | Parent interrupt line |

## Verification
The checker watches several rules on every cycle. It confirms that every source seen high at an edge is latched, and that a cause write lands as the written value merged with the simultaneous sources. It also checks that the parent line follows the enabled pending set one cycle later, that upper bits read 0, and that the 0x5C word always names the top pending enabled bit. The bench scenarios cover the rest. These are the reset values, masked causes staying silent, writes of 1 raising a cause, a held source surviving a clearing write, and writes to the read-only and unmapped offsets leaving every register unchanged.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;

    localparam int unsigned BUS_ADDR_W = 8;
    localparam int unsigned BUS_DATA_W = 32;

    localparam logic [BUS_ADDR_W-1:0] OFS_CAUSE  = 8'h50;
    localparam logic [BUS_ADDR_W-1:0] OFS_ENABLE = 8'h54;
    localparam logic [BUS_ADDR_W-1:0] OFS_TOP    = 8'h5C;

    localparam int unsigned TOP_VALID_BIT = 31;

    typedef enum logic [0:0] {
        LINE_QUIET  = 1'b0,
        LINE_RAISED = 1'b1
    } line_state_e;

endpackage

// File: rtl/irqagg_bitreg.sv
module irqagg_bitreg #(
    parameter int unsigned WIDTH   = 7,
    parameter bit          HAS_SET = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] set_i,
    input  logic             load_i,
    input  logic [WIDTH-1:0] load_val_i,
    output logic [WIDTH-1:0] q_o
);

    for (genvar g = 0; g < WIDTH; g++) begin : g_bit
        logic bit_q;

        if (HAS_SET) begin : g_settable
            // hardware event outranks a software load in the same cycle
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    bit_q <= 1'b0;
                end else if (set_i[g]) begin
                    bit_q <= 1'b1;
                end else if (load_i) begin
                    bit_q <= load_val_i[g];
                end
            end
        end else begin : g_plain
            logic unused_set;
            assign unused_set = set_i[g];

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    bit_q <= 1'b0;
                end else if (load_i) begin
                    bit_q <= load_val_i[g];
                end
            end
        end

        assign q_o[g] = bit_q;
    end

endmodule

// File: rtl/irqagg_prio.sv
module irqagg_prio #(
    parameter int unsigned WIDTH = 7,
    parameter int unsigned IDX_W = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
    input  logic [WIDTH-1:0] pend_i,
    output logic             valid_o,
    output logic [IDX_W-1:0] idx_o
);

    always_comb begin
        valid_o = 1'b0;
        idx_o   = '0;
        // ascending scan: the last hit is the highest index
        for (int i = 0; i < WIDTH; i++) begin
            if (pend_i[i]) begin
                valid_o = 1'b1;
                idx_o   = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/irqagg_line.sv
module irqagg_line
    import irqagg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic any_i,
    output logic irq_o
);

    line_state_e state_q;
    line_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= LINE_QUIET;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LINE_QUIET: begin
                if (any_i) begin
                    state_d = LINE_RAISED;   // RAISE
                end
            end
            LINE_RAISED: begin
                if (!any_i) begin
                    state_d = LINE_QUIET;    // DROP
                end
            end
            default: state_d = LINE_QUIET;
        endcase
    end

    always_comb begin
        unique case (state_q)
            LINE_RAISED: irq_o = 1'b1;
            default:     irq_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/irqagg_top.sv
module irqagg_top
    import irqagg_pkg::*;
#(
    parameter int unsigned NUM_SRC = 7
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_SRC-1:0]    src_i,
    input  logic                  wr_en,
    input  logic [BUS_ADDR_W-1:0] addr,
    input  logic [BUS_DATA_W-1:0] wdata,
    output logic [BUS_DATA_W-1:0] rdata,
    output logic                  irq_o
);

    localparam int unsigned IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

    logic [NUM_SRC-1:0] cause_q;
    logic [NUM_SRC-1:0] enable_q;
    logic [NUM_SRC-1:0] pend;
    logic               top_valid;
    logic [IDX_W-1:0]   top_idx;
    logic               ld_cause;
    logic               ld_enable;
    logic               unused_wdata_hi;

    assign unused_wdata_hi = ^wdata[BUS_DATA_W-1:NUM_SRC];

    assign ld_cause  = wr_en && (addr == OFS_CAUSE);
    assign ld_enable = wr_en && (addr == OFS_ENABLE);

    irqagg_bitreg #(.WIDTH(NUM_SRC), .HAS_SET(1'b1)) u_cause (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_i      (src_i),
        .load_i     (ld_cause),
        .load_val_i (wdata[NUM_SRC-1:0]),
        .q_o        (cause_q)
    );

    irqagg_bitreg #(.WIDTH(NUM_SRC), .HAS_SET(1'b0)) u_enable (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_i      ('0),
        .load_i     (ld_enable),
        .load_val_i (wdata[NUM_SRC-1:0]),
        .q_o        (enable_q)
    );

    assign pend = cause_q & enable_q;

    irqagg_prio #(.WIDTH(NUM_SRC), .IDX_W(IDX_W)) u_prio (
        .pend_i  (pend),
        .valid_o (top_valid),
        .idx_o   (top_idx)
    );

    irqagg_line u_line (
        .clk   (clk),
        .rst_n (rst_n),
        .any_i (|pend),
        .irq_o (irq_o)
    );

    always_comb begin
        rdata = '0;
        case (addr)
            OFS_CAUSE:  rdata[NUM_SRC-1:0] = cause_q;
            OFS_ENABLE: rdata[NUM_SRC-1:0] = enable_q;
            OFS_TOP: begin
                rdata[TOP_VALID_BIT] = top_valid;
                rdata[IDX_W-1:0]     = top_idx;
            end
            default:    rdata = '0;
        endcase
    end

endmodule

// File: rtl/irqagg_checker.sv
module irqagg_checker
    import irqagg_pkg::*;
#(
    parameter int unsigned NUM_SRC = 7
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [NUM_SRC-1:0]    src_i,
    input logic                  wr_en,
    input logic [BUS_ADDR_W-1:0] addr,
    input logic [NUM_SRC-1:0]    wdata_lo,
    input logic [BUS_DATA_W-1:0] rdata,
    input logic                  irq_o,
    input logic [NUM_SRC-1:0]    cause_q,
    input logic [NUM_SRC-1:0]    enable_q
);

    localparam int unsigned IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

    logic [NUM_SRC-1:0] pend;
    assign pend = cause_q & enable_q;

    // R2: every source seen high at the previous edge is latched
    p_src_latched_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((cause_q & $past(src_i)) == $past(src_i)));

    // R3 and R4: a cause write yields the written value merged with sources
    p_cause_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(wr_en) && ($past(addr) == OFS_CAUSE))
        |-> (cause_q == ($past(wdata_lo) | $past(src_i))));

    // R6: the parent line follows the enabled pending set one cycle later
    p_line_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (|pend) |=> irq_o);

    p_line_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(|pend) |=> !irq_o);

    // R5: upper bits of the cause and enable words read zero
    p_upper_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((addr == OFS_CAUSE) || (addr == OFS_ENABLE))
        |-> (rdata[BUS_DATA_W-1:NUM_SRC] == '0));

    // R7: valid flag matches the pending set
    p_top_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == OFS_TOP) |-> (rdata[TOP_VALID_BIT] == (|pend)));

    // R7: reported index is the highest pending enabled bit
    p_top_index_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((addr == OFS_TOP) && rdata[TOP_VALID_BIT])
        |-> ((pend >> rdata[IDX_W-1:0]) == NUM_SRC'(1)));

endmodule

bind irqagg_top irqagg_checker #(.NUM_SRC(NUM_SRC)) u_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .src_i    (src_i),
    .wr_en    (wr_en),
    .addr     (addr),
    .wdata_lo (wdata[NUM_SRC-1:0]),
    .rdata    (rdata),
    .irq_o    (irq_o),
    .cause_q  (cause_q),
    .enable_q (enable_q)
);

// File: tb/irqagg_top_test.sv
module irqagg_top_test;
    import irqagg_pkg::*;

    typedef struct {
        logic [7:0]  a;
        logic [31:0] data;
        logic        irq;
        string       tag;
    } item_t;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [6:0]  src;
    logic        wr_en;
    logic [7:0]  addr;
    logic [31:0] wdata;
    logic [31:0] rdata;
    logic        irq;

    int  checks = 0;
    int  errors = 0;
    bit  done   = 1'b0;
    item_t sb[$];

    logic [6:0] cause_m;
    logic [6:0] enable_m;
    logic       irq_m;

    always #10 clk = ~clk;

    irqagg_top uut (
        .clk   (clk),
        .rst_n (rst_n),
        .src_i (src),
        .wr_en (wr_en),
        .addr  (addr),
        .wdata (wdata),
        .rdata (rdata),
        .irq_o (irq)
    );

    function automatic logic [31:0] expect_rd(input logic [7:0] a);
        logic [6:0]  p;
        logic [31:0] r;
        p = cause_m & enable_m;
        r = 32'h0;
        if (a == OFS_CAUSE) r = {25'h0, cause_m};
        else if (a == OFS_ENABLE) r = {25'h0, enable_m};
        else if (a == OFS_TOP) begin
            for (int i = 0; i < 7; i++) begin
                if (p[i]) r = 32'h8000_0000 | 32'(i);
            end
        end
        return r;
    endfunction

    // one clock: model follows the requirements at the rising edge
    task automatic cycle();
        @(posedge clk);
        irq_m = |(cause_m & enable_m);
        if (wr_en && addr == OFS_CAUSE)  cause_m  = wdata[6:0];
        if (wr_en && addr == OFS_ENABLE) enable_m = wdata[6:0];
        cause_m = cause_m | src;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        addr  = a;
        wdata = d;
        wr_en = 1'b1;
        cycle();
    endtask

    task automatic chk(input logic [7:0] a, input string tag);
        item_t it;
        addr    = a;
        it.a    = a;
        it.data = expect_rd(a);
        it.irq  = irq_m;
        it.tag  = tag;
        sb.push_back(it);
        cycle();
    endtask

    // monitor: compare the scoreboard against the ports between edges
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (sb.size() > 0) begin
                item_t it;
                it = sb.pop_front();
                checks++;
                if (rdata !== it.data || irq !== it.irq) begin
                    errors++;
                    $display("FAIL %s: addr %h rdata %h expected %h, irq %b expected %b",
                             it.tag, it.a, rdata, it.data, irq, it.irq);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, actual hung expected done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; src = '0; wr_en = 1'b0; addr = '0; wdata = '0;
        cause_m = '0; enable_m = '0; irq_m = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset values
        chk(OFS_CAUSE,  "R1 cause");
        chk(OFS_ENABLE, "R1 enable");
        chk(OFS_TOP,    "R1 top");

        // R2 and R9: masked source latches but stays silent
        src = 7'h08; cycle(); src = '0;
        chk(OFS_CAUSE, "R2 latch");
        chk(OFS_TOP,   "R9 masked");

        // R6 and R7: enabling raises the line one cycle later
        wr(OFS_ENABLE, 32'h08);
        chk(OFS_TOP, "R6 lag");
        chk(OFS_TOP, "R7 index3");

        // R3: writing 1 raises causes, 0 clears
        wr(OFS_CAUSE, 32'h41);
        chk(OFS_CAUSE,  "R3 load");
        chk(OFS_ENABLE, "R6 drop");
        wr(OFS_ENABLE, 32'h7F);
        cycle();
        chk(OFS_TOP, "R7 index6");

        // R5: upper bits dropped
        wr(OFS_ENABLE, 32'hFFFF_FF85);
        chk(OFS_ENABLE, "R5 enable");
        wr(OFS_CAUSE, 32'hFFFF_FFFF);
        chk(OFS_CAUSE, "R5 cause");
        chk(OFS_TOP,   "R7 index2");

        // R4: event in the same cycle as a clearing write wins
        src = 7'h04;
        wr(OFS_CAUSE, 32'h0);
        src = '0;
        chk(OFS_CAUSE, "R4 same cycle");
        src = 7'h10;
        wr(OFS_CAUSE, 32'h0);
        chk(OFS_CAUSE, "R4 held level");
        src = '0;
        wr(OFS_CAUSE, 32'h0);
        chk(OFS_CAUSE, "R3 clear");

        // R8: read-only and unmapped offsets
        wr(OFS_ENABLE, 32'h03);
        wr(OFS_CAUSE,  32'h02);
        wr(OFS_TOP,    32'hFFFF_FFFF);
        wr(8'h60,      32'hFFFF_FFFF);
        wr(8'h51,      32'h0000_007F);
        chk(8'h60,      "R8 unmapped read");
        chk(OFS_CAUSE,  "R8 cause kept");
        chk(OFS_ENABLE, "R8 enable kept");
        chk(OFS_TOP,    "R8 top kept");

        // R3: zero to both words clears everything
        wr(OFS_ENABLE, 32'h0);
        wr(OFS_CAUSE,  32'h0);
        cycle();
        chk(OFS_CAUSE, "R3 init cause");
        chk(OFS_TOP,   "R3 init top");

        cycle();
        cycle();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule